// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is a bank of general-purpose I/O bits. Each bit has a direction bit, an output latch and a read path from the pin. Any bit can be handed to an on-chip peripheral. The peripheral supplies its own output value and output enable, and it holds the pin only while it asserts that enable. A small register bus writes and reads three views of the bank: direction, latch and port. A write to the port view lands in the latch. A read of the port view returns the synchronised pin levels, not the latch.

Pin levels pass through a two-flop synchroniser. The synchronised value feeds both the port read path and the peripheral input, so a peripheral always sees the real pin and never the port's own output latch. A mask parameter marks which bits exist. Bits outside the mask read as zero, ignore writes and never drive their pin.

Top module: `shared_gpio_port`

## Requirements
- R1: After synchronous reset, the direction view reads all ones in the implemented bits (every pin is an input), the latch view reads zero, and no pin is driven while the peripheral is disabled.
- R2: A direction bit of 0 makes its pin an output that drives the latch value with pin_oe high. A direction bit of 1 leaves pin_oe low. The direction view (bus_sel = 0) reads back the written value.
- R3: Reading the latch view (bus_sel = 1) returns the stored latch value, whatever level the pin carries.
- R4: Reading the port view (bus_sel = 2) returns the pin level. A change on pin_in first appears two clock edges after it is applied, and is not yet visible after one edge.
- R5: A write to the port view (bus_sel = 2) updates the output latch. The latch view and the driven pin value both show the written data.
- R6: While per_en is high, every implemented bit with per_oe high takes pin_out from per_out and drives pin_oe high. This holds even if its direction bit is 1. The port view can still read that pin.
- R7: While per_en is high, every bit with per_oe low stays under latch and direction control. per_out has no effect on that bit.
- R8: While per_en is low, per_oe and per_out have no effect on any pin.
- R9: Bits outside IMPL_MASK read as zero in all three views and on per_in. Writes to them are ignored. Their pin_oe and pin_out stay low, even when the peripheral requests them.
- R10: per_in carries the synchronised pin level (two edges after pin_in) and never the output latch.
- R11: Register select value 3 is unused. Reads return zero, and writes change neither the direction nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data from the selected view (combinational) |
| per_en | input | 1 | Peripheral module enable |
| per_oe | input | WIDTH | Peripheral output enable, one bit per pin |
| per_out | input | WIDTH | Peripheral output data, one bit per pin |
| per_in | output | WIDTH | Synchronised pin level toward the peripheral |
| pin_in | input | WIDTH | Level sensed at each pin |
| pin_out | output | WIDTH | Output value toward each pin |
| pin_oe | output | WIDTH | Output driver enable toward each pin |

## Verification
The bench holds the pin at a level that differs from the latch. This exposes a design that returns the latch on a port read, or that feeds per_in from the latch. Such a design would show the latch value where the pin level belongs. It checks the synchroniser one edge and two edges after a pin change, which catches a missing or extra stage. It separates per_en from per_oe to catch three faults: a design that lets the peripheral win while it is disabled, one that takes a pin the peripheral is not driving, or one that lets the direction bit block a peripheral-owned pin. Finally, it writes all ones to the unimplemented top bit, to the unused select code and through a peripheral request. A masking error would then show up as a stray one in a read or on the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_PORT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Drive decision for one pin
    typedef struct packed {
        logic data;
        logic en;
    } pin_drive_t;

    // Both the latch view and the port view write the output latch
    function automatic logic hits_latch(input logic [1:0] sel);
        return (sel == SEL_LAT) || (sel == SEL_PORT);
    endfunction

    function automatic logic hits_dir(input logic [1:0] sel);
        return sel == SEL_DIR;
    endfunction

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);

    logic [WIDTH-1:0] wdata_m;
    assign wdata_m = wdata & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= IMPL_MASK;
            lat_q <= '0;
        end else if (wr) begin
            if (hits_dir(sel))
                dir_q <= wdata_m;
            if (hits_latch(sel))
                lat_q <= wdata_m;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic             per_en,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (IMPL_MASK[i]) begin : g_impl
                pin_drive_t drv;
                always_comb begin
                    if (per_en && per_oe[i]) begin
                        drv.data = per_out[i];
                        drv.en   = 1'b1;
                    end else begin
                        drv.data = lat_q[i];
                        drv.en   = ~dir_q[i];
                    end
                end
                assign pin_out[i] = drv.data;
                assign pin_oe[i]  = drv.en;
            end else begin : g_absent
                assign pin_out[i] = 1'b0;
                assign pin_oe[i]  = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = {1'b0, {(WIDTH-1){1'b1}}},
    parameter int              SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             per_en,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] per_in,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_ctrl_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (bus_sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_mux (
        .per_en  (per_en),
        .per_oe  (per_oe),
        .per_out (per_out),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // The peripheral sees the pin, never the latch
    assign per_in = pin_sync & IMPL_MASK;

    always_comb begin
        unique case (bus_sel)
            SEL_DIR:  bus_rdata = dir_q;
            SEL_LAT:  bus_rdata = lat_q;
            SEL_PORT: bus_rdata = pin_sync & IMPL_MASK;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/shared_gpio_port_checker.sv
module shared_gpio_port_checker #(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_sel,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic             per_en,
    input logic [WIDTH-1:0] per_oe,
    input logic [WIDTH-1:0] per_out,
    input logic [WIDTH-1:0] per_in,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe
);

    logic [1:0] since_rst;
    logic [WIDTH-1:0] owned;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign owned = per_oe & IMPL_MASK;

    // R1: the cycle after reset, nothing drives unless the peripheral is enabled
    assert_reset_inputs_R1: assert property (@(posedge clk)
        ($past(rst) && !rst && !per_en) |-> (pin_oe == '0));

    // R4, R10: port view and peripheral input trail the pin by two edges
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |->
            ((per_in == ($past(pin_in, 2) & IMPL_MASK)) &&
             ((bus_sel != 2'd2) || (bus_rdata == ($past(pin_in, 2) & IMPL_MASK)))));

    // R5: port-view write appears on the pin side when the port owns it
    assert_port_write_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd2) |=>
            (per_en || ((pin_out & IMPL_MASK) == ($past(bus_wdata) & IMPL_MASK))));

    // R6: an enabled peripheral wins on every bit it drives
    assert_periph_owns_R6: assert property (@(posedge clk) disable iff (rst)
        per_en |-> (((pin_oe & owned) == owned) &&
                    ((pin_out & owned) == (per_out & owned))));

    // R9: bits outside the mask stay quiet everywhere
    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ((bus_rdata | per_in | pin_out | pin_oe) & ~IMPL_MASK) == '0);

    // R11: unused select reads zero
    assert_unused_sel_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd3) |-> (bus_rdata == '0));

endmodule

bind shared_gpio_port shared_gpio_port_checker #(
    .WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_en(per_en),
    .per_oe(per_oe), .per_out(per_out), .per_in(per_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/shared_gpio_port_bench.sv
module shared_gpio_port_bench;

    localparam int         W    = 8;
    localparam logic [7:0] MASK = 8'h7F;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_sel = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         per_en = 1'b0;
    logic [W-1:0] per_oe = '0;
    logic [W-1:0] per_out = '0;
    logic [W-1:0] per_in;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    shared_gpio_port #(.WIDTH(W), .IMPL_MASK(MASK), .SYNC_LEN(2)) u_shared_gpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_en(per_en),
        .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [W-1:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [W-1:0] data);
        @(negedge clk);
        bus_sel = sel;
        #2 data = bus_rdata;
    endtask

    task automatic settle_pin(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] r;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_read(2'd0, r); check("R1 dir after reset", r, MASK);
        bus_read(2'd1, r); check("R1 latch after reset", r, 8'h00);
        check("R1 pin_oe after reset", pin_oe, 8'h00);
    endtask

    task automatic t_direction;
        logic [W-1:0] r;
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'hA5);
        bus_read(2'd0, r); check("R2 dir readback", r, 8'h70);
        check("R2 pin_oe from dir", pin_oe, 8'h0F);
        check("R2 pin_out from latch", pin_out, 8'h25);
    endtask

    task automatic t_latch_vs_pin;
        logic [W-1:0] r;
        settle_pin(8'h5A);
        bus_read(2'd1, r); check("R3 latch not pin", r, 8'h25);
        bus_read(2'd2, r); check("R4 port reads pin", r, 8'h5A);
        settle_pin(8'h00);
        @(negedge clk); pin_in = 8'h33; bus_sel = 2'd2;
        @(negedge clk); #2 check("R4 not visible after one edge", bus_rdata, 8'h00);
        @(negedge clk); #2 check("R4 visible after two edges", bus_rdata, 8'h33);
    endtask

    task automatic t_port_write;
        logic [W-1:0] r;
        bus_write(2'd2, 8'h3C);
        bus_read(2'd1, r); check("R5 port write to latch", r, 8'h3C);
        check("R5 pin_out follows latch", pin_out, 8'h3C);
        bus_read(2'd2, r); check("R4 port still shows pin", r, 8'h33);
    endtask

    task automatic t_periph;
        logic [W-1:0] r;
        bus_write(2'd0, 8'h7F);
        bus_write(2'd1, 8'h55);
        @(negedge clk); per_en = 1'b1; per_oe = 8'h0F; per_out = 8'h0A;
        #2 check("R6 pin_out from peripheral", pin_out, 8'h5A);
        check("R6 pin_oe forced by peripheral", pin_oe, 8'h0F);
        settle_pin(8'h06);
        bus_read(2'd2, r); check("R6 owned pin still readable", r, 8'h06);
        bus_write(2'd0, 8'h0F);
        @(negedge clk); per_oe = 8'h01; per_out = 8'hFE;
        #2 check("R7 non-driving bits stay with port oe", pin_oe, 8'h71);
        check("R7 non-driving bits stay with port data", pin_out, 8'h54);
        @(negedge clk); per_en = 1'b0; per_oe = 8'hFF; per_out = 8'hAA;
        #2 check("R8 disabled peripheral ignored oe", pin_oe, 8'h70);
        check("R8 disabled peripheral ignored data", pin_out, 8'h55);
        @(negedge clk); per_oe = '0; per_out = '0;
    endtask

    task automatic t_unimpl;
        logic [W-1:0] r;
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, r); check("R9 dir top bit zero", r, 8'h7F);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, r); check("R9 latch top bit zero", r, 8'h7F);
        settle_pin(8'hFF);
        bus_read(2'd2, r); check("R9 port top bit zero", r, 8'h7F);
        check("R9 per_in top bit zero", per_in, 8'h7F);
        bus_write(2'd0, 8'h00);
        @(negedge clk); per_en = 1'b1; per_oe = 8'h80; per_out = 8'h80;
        #2 check("R9 top pin never driven", pin_oe, 8'h7F);
        check("R9 top pin data low", pin_out, 8'h7F);
        @(negedge clk); per_en = 1'b0; per_oe = '0; per_out = '0;
    endtask

    task automatic t_loop_through;
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h7F);
        settle_pin(8'h00);
        check("R10 per_in from pin not latch", per_in, 8'h00);
        @(negedge clk); pin_in = 8'h12;
        @(negedge clk); #2 check("R10 per_in after one edge", per_in, 8'h00);
        @(negedge clk); #2 check("R10 per_in after two edges", per_in, 8'h12);
    endtask

    task automatic t_unused_sel;
        logic [W-1:0] r;
        bus_write(2'd0, 8'h0F);
        bus_write(2'd1, 8'h21);
        bus_read(2'd3, r); check("R11 unused select reads zero", r, 8'h00);
        bus_write(2'd3, 8'h7F);
        bus_read(2'd0, r); check("R11 dir untouched", r, 8'h0F);
        bus_read(2'd1, r); check("R11 latch untouched", r, 8'h21);
    endtask

    initial begin
        t_reset();
        t_direction();
        t_latch_vs_pin();
        t_port_write();
        t_periph();
        t_unimpl();
        t_loop_through();
        t_unused_sel();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule